// File: doc/BRIEF.md
# Windowed Watchdog Timer with Keyed Refresh

This block supervises software by counting ticks of a prescaled watchdog clock toward a programmable 32-bit timeout. Software keeps the system alive by writing a two-word key into a 16-bit refresh register. The pair is accepted only when the words are correct, the second word closely follows the first, and, in windowed mode, the count has already reached a programmable 32-bit lower bound. The bound is held as separate high and low 16-bit halves.

A wrong key word, a late second word, a refresh that comes too early, or a count that reaches the timeout all count as a fault. A fault either drives the system reset at once, or first raises an interrupt and drives the reset a fixed number of watchdog ticks later. Software programs the block over a simple write-strobe bus with a combinational read port. Both fault outputs stay high until the block's own reset.

Top module: `wdog_window`

## Requirements
- R1: After reset, the key register reads 0xB480, the window low half reads 0x0010, the window high half reads 0x0000, the timeout reads TOUT_INIT, control reads 0b001 (enabled, window off, interrupt off), and irq and sys_rst are low.
- R2: While enabled (control bit 0), the count increases by one on each clock with tick high. While disabled, the count holds and key writes raise no fault.
- R3: Writing 0xA602 and then 0xB480 to the key address (5) clears the count to 0 on the clock of the second write. The tracker then waits for a new first word.
- R4: A key write whose value is not the expected next word (0xA602 first, 0xB480 second) is a fault.
- R5: If the first word is written on clock t, a second word on clock t+k is accepted for k up to KEY_GAP (20). For a larger k, the second word is a fault.
- R6: With window mode on (control bit 1), a key pair that completes while count < window is a fault, and one that completes at count >= window is accepted. With window mode off, a pair is accepted at any count.
- R7: When the count reaches the timeout value, the next clock records a fault.
- R8: With interrupt mode off (control bit 2 = 0), sys_rst goes high on the clock after the fault. It stays high, and the block ignores key writes, until rst_n.
- R9: With interrupt mode on, irq goes high on the clock after the fault while sys_rst stays low. sys_rst then rises after RST_DELAY further clocks with tick high.
- R10: Register addresses: 0 control, 1 timeout high, 2 timeout low, 3 window high, 4 window low, 5 key (reads the last value written), 6 count high, 7 count low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled watchdog clock enable |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Write register address |
| wr_data | input | 16 | Write data |
| rd_addr | input | 3 | Read register address |
| rd_data | output | 16 | Read data (combinational) |
| irq | output | 1 | Fault interrupt |
| sys_rst | output | 1 | System reset request |

## Verification
The bench builds the block with TOUT_INIT = 200 and RST_DELAY = 8, and keeps KEY_GAP at 20. With these values a timeout, the full interrupt-to-reset delay and the exact key-gap limit all happen within a few hundred clocks. The tick input is driven directly, so the count at the moment a refresh completes is exact. This allows tests that refresh exactly at the window value and exactly one tick below it.

// File: rtl/wdog_window.sv
module wdog_window #(
  parameter int          KEY_GAP   = 20,
  parameter int          RST_DELAY = 128,
  parameter logic [31:0] TOUT_INIT = 32'h004C_4B40,
  parameter logic [15:0] WIN_LO_INIT = 16'h0010
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [2:0]  rd_addr,
  output logic [15:0] rd_data,
  output logic        irq,
  output logic        sys_rst
);
  localparam int GW = $clog2(KEY_GAP + 1);
  localparam int DW = $clog2(RST_DELAY + 1);
  localparam logic [15:0] KEY_A = 16'hA602;
  localparam logic [15:0] KEY_B = 16'hB480;

  logic [2:0]    ctrl;
  logic [31:0]   tout, win, cnt;
  logic [15:0]   key_q;
  logic          armed, flt;
  logic [GW-1:0] gap;
  logic [DW-1:0] dly;

  wire en      = ctrl[0];
  wire key_wr  = wr_en && wr_addr == 3'd5 && en && !flt;
  wire first_ok  = wr_data == KEY_A;
  wire second_ok = wr_data == KEY_B && gap < GW'(KEY_GAP);
  wire win_ok  = !ctrl[1] || cnt >= win;
  wire good    = key_wr && armed && second_ok && win_ok;
  wire bad_key = key_wr && (armed ? !(second_ok && win_ok) : !first_ok);
  wire tmo     = en && !flt && cnt >= tout;
  wire ev      = bad_key || tmo;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl  <= 3'b001;
      tout  <= TOUT_INIT;
      win   <= {16'h0000, WIN_LO_INIT};
      key_q <= KEY_B;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: ctrl <= wr_data[2:0];
        3'd1: tout[31:16] <= wr_data;
        3'd2: tout[15:0]  <= wr_data;
        3'd3: win[31:16]  <= wr_data;
        3'd4: win[15:0]   <= wr_data;
        3'd5: key_q <= wr_data;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else if (good) cnt <= '0;
    else if (en && tick && !flt) cnt <= cnt + 32'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed <= 1'b0;
      gap   <= '0;
    end else if (key_wr) begin
      armed <= !armed && first_ok;
      gap   <= '0;
    end else if (armed && gap != GW'(KEY_GAP)) begin
      gap <= gap + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      flt     <= 1'b0;
      dly     <= '0;
      sys_rst <= 1'b0;
    end else begin
      if (ev) flt <= 1'b1;
      if (flt && tick && !sys_rst && dly != DW'(RST_DELAY)) dly <= dly + 1'b1;
      if ((ev || flt) && !ctrl[2]) sys_rst <= 1'b1;
      else if (flt && tick && dly == DW'(RST_DELAY - 1)) sys_rst <= 1'b1;
    end

  assign irq = flt && ctrl[2];

  always_comb
    case (rd_addr)
      3'd0: rd_data = {13'd0, ctrl};
      3'd1: rd_data = tout[31:16];
      3'd2: rd_data = tout[15:0];
      3'd3: rd_data = win[31:16];
      3'd4: rd_data = win[15:0];
      3'd5: rd_data = key_q;
      3'd6: rd_data = cnt[31:16];
      default: rd_data = cnt[15:0];
    endcase
endmodule

// File: rtl/wdog_window_chk.sv
module wdog_window_chk #(
  parameter int KEY_GAP = 20,
  parameter int GW = 5
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [15:0] wr_data,
  input logic        irq,
  input logic        sys_rst,
  input logic [2:0]  ctrl,
  input logic [31:0] cnt,
  input logic [31:0] win,
  input logic        armed,
  input logic [GW-1:0] gap,
  input logic        flt
);
  wire key_w = wr_en && wr_addr == 3'd5 && ctrl[0] && !flt;

  // R8
  rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst |=> sys_rst);

  // R9
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ctrl[2]);

  // R9
  irq_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(irq)) |-> !sys_rst);

  // R3
  refresh_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_w && armed && wr_data == 16'hB480 && gap < GW'(KEY_GAP) &&
     (!ctrl[1] || cnt >= win)) |=> cnt == 32'd0);

  // R4
  bad_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_w && !armed && wr_data != 16'hA602) |=> (irq || sys_rst));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !(wr_en && wr_addr == 3'd0)) |=> $stable(cnt));
endmodule

bind wdog_window wdog_window_chk #(.KEY_GAP(KEY_GAP), .GW(GW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .irq(irq), .sys_rst(sys_rst), .ctrl(ctrl),
  .cnt(cnt), .win(win), .armed(armed), .gap(gap), .flt(flt)
);

// File: tb/wdog_window_test.sv
`timescale 1ns/1ps
module wdog_window_test;
  localparam int RD = 8;
  localparam logic [31:0] TO = 32'd200;

  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [2:0] wr_addr = 0, rd_addr = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic irq, sys_rst;
  int checks = 0, fails = 0;
  bit done = 0;

  wdog_window #(.KEY_GAP(20), .RST_DELAY(RD), .TOUT_INIT(TO)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq(irq), .sys_rst(sys_rst));

  always #2.5 clk = ~clk;

  // {key1, key2, gap, window_on, ticks, expect_fault}
  localparam logic [49:0] VEC [9] = '{
    {16'hA602, 16'hB480, 8'd1,  1'b0, 8'd5,  1'b0},
    {16'hA602, 16'hB480, 8'd3,  1'b0, 8'd2,  1'b0},
    {16'hA602, 16'hB480, 8'd1,  1'b1, 8'd20, 1'b0},
    {16'hA602, 16'hB480, 8'd1,  1'b1, 8'd16, 1'b0},
    {16'hA602, 16'hB480, 8'd1,  1'b1, 8'd15, 1'b1},
    {16'h1234, 16'hB480, 8'd1,  1'b0, 8'd5,  1'b1},
    {16'hA602, 16'h1111, 8'd1,  1'b0, 8'd5,  1'b1},
    {16'hA602, 16'hB480, 8'd20, 1'b0, 8'd5,  1'b0},
    {16'hA602, 16'hB480, 8'd21, 1'b0, 8'd5,  1'b1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; tick = 0; wr_en = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_addr = a; wr_data = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) @(negedge clk);
    tick = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    do_reset();
    // R1 reset state
    rd(3'd5, d); chk("R1 key", d, 16'hB480);
    rd(3'd4, d); chk("R1 winlo", d, 16'h0010);
    rd(3'd3, d); chk("R1 winhi", d, 16'h0000);
    rd(3'd2, d); chk("R1 toutlo", d, TO[15:0]);
    rd(3'd0, d); chk("R1 ctrl", d, 16'h0001);
    chk("R1 irq", irq, 0);
    chk("R1 sys_rst", sys_rst, 0);

    // R3 R4 R5 R6 vector table
    for (int i = 0; i < 9; i++) begin
      logic [49:0] v;
      v = VEC[i];
      do_reset();
      if (v[9]) wr(3'd0, 16'h0003);
      ticks(int'(v[8:1]));
      wr(3'd5, v[49:34]);
      repeat (int'(v[17:10]) - 1) @(negedge clk);
      wr(3'd5, v[33:18]);
      chk($sformatf("R3/R4/R5/R6 vec%0d fault", i), sys_rst, v[0]);
      if (!v[0]) begin
        rd(3'd7, d); chk($sformatf("R3 vec%0d count", i), d, 16'd0);
      end
    end

    // R2 counting and R7 timeout
    do_reset();
    ticks(200);
    rd(3'd7, d); chk("R2 count", d, 16'd200);
    chk("R7 no early fault", sys_rst, 0);
    @(negedge clk);
    chk("R7 timeout fault", sys_rst, 1);
    // R8 sticky, key pair ignored
    wr(3'd5, 16'hA602); wr(3'd5, 16'hB480);
    repeat (3) @(negedge clk);
    chk("R8 sticky", sys_rst, 1);

    // R2 disabled: holds, ignores key writes; R10 key readback
    do_reset();
    wr(3'd0, 16'h0000);
    ticks(10);
    wr(3'd5, 16'h1234);
    @(negedge clk);
    chk("R2 disabled no fault", sys_rst, 0);
    rd(3'd7, d); chk("R2 disabled hold", d, 16'd0);
    rd(3'd5, d); chk("R10 key readback", d, 16'h1234);

    // R10 window high half write/read
    wr(3'd3, 16'h00AB);
    rd(3'd3, d); chk("R10 winhi", d, 16'h00AB);

    // R9 interrupt then reset
    do_reset();
    wr(3'd0, 16'h0005);
    wr(3'd5, 16'h0BAD);
    chk("R9 irq", irq, 1);
    chk("R9 no reset yet", sys_rst, 0);
    tick = 1;
    repeat (RD - 1) @(negedge clk);
    chk("R9 reset before delay", sys_rst, 0);
    @(negedge clk);
    chk("R9 reset after delay", sys_rst, 1);
    tick = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule